// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Master

This block drives a 3-wire serial EEPROM that holds 64 words of 16 bits. It owns the chip select, shift clock and serial data-in lines, and it samples the device's serial data-out line. A host pulses `req_i` with an operation code, a word address and, for writes, a 16-bit word. The block then runs one complete access and pulses `done_o`. A read leaves the fetched word on `rdata_o`. A write first waits for the device to report that it is ready, and it raises `timeout_o` if the device never does.

Each access is a fixed sequence of half bit-times, which this document calls phases. Every phase lasts `HALF_CYCLES` system clocks, and a shared pacer sets that length. The FSM states and their transitions, each taken at the end of a phase, are:

- IDLE goes to LEAD on an accepted read, or to CMD_LO on any other accepted operation.
- LEAD goes to CMD_LO, and CMD_LO goes to CMD_HI.
- CMD_HI goes back to CMD_LO until the last command bit has been sent. It then goes to GAP for a read, WR_LO for a write, or DROP_LO for a write-enable.
- GAP goes to RD_HI. RD_HI and RD_LO alternate, and after the 16th RD_LO the FSM goes to FIN_CS.
- WR_LO and WR_HI alternate, and after the 16th WR_HI the FSM goes to DROP_LO.
- DROP_LO goes to DROP_HI. DROP_HI goes to POLL for a write, or to FIN_CS for a write-enable.
- POLL stays in POLL until data-out reads 1 or the poll limit is reached, then goes to FIN_CS.
- FIN_CS goes to FIN_OFF, and FIN_OFF goes to IDLE.

Top module: `uw_eeprom_master`

## Requirements
- R1: After reset, busy_o, done_o, timeout_o, cs_o, sk_o and di_o are 0 and rdata_o is 0. While the block is idle, cs_o, sk_o and di_o stay 0.
- R2: In the idle state, a req_i with op_i equal to 2'b00 (write-enable), 2'b01 (write) or 2'b10 (read) is accepted. busy_o is 1 from the next cycle. A request with op_i = 2'b11 is ignored: busy_o and cs_o stay 0.
- R3: Every phase lasts exactly HALF_CYCLES clocks. Every high pulse of sk_o is therefore HALF_CYCLES clocks wide.
- R4: Command bits leave MSB-first. Each command bit is driven on di_o during a low phase and held through the following high phase. di_o never changes while sk_o is high.
- R5: A read starts with one phase in which cs_o=1, sk_o=0 and di_o=0. It then clocks out 11 command bits, 0,0,1,1,0,a5..a0. Next comes one phase with sk_o low, then 16 clock pulses. data-out is sampled at the end of each high phase, and the first bit sampled becomes rdata_o[0]. A read occupies 58 phases.
- R6: A write clocks out the 10 command bits 0,1,0,1,a5..a0, followed at once by wdata_i LSB-first over 16 clocks.
- R7: A write-enable clocks out the 10 command bits 0,1,0,0,1,1,a3..a0. After a write-enable, and after the write data, cs_o drops and exactly one sk_o pulse is given with cs_o low. A write-enable occupies 24 phases.
- R8: After that pulse, a write raises cs_o again with sk_o and di_o low. It samples do_i once per phase and ends polling at the first 1. If the first poll already sees 1, the write occupies 57 phases.
- R9: If POLL_LIMIT poll phases pass without do_i=1, the write ends with timeout_o=1 after 56+POLL_LIMIT phases. timeout_o is held until the next accepted request clears it.
- R10: Every access ends with one phase of cs_o=1 and sk_o=0, then one phase of cs_o=0. done_o then pulses for exactly one cycle, in the first idle cycle, and rdata_o keeps its value.
- R11: A req_i that arrives while busy_o is 1 is ignored. The access in progress runs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 1 | Start request, sampled only when idle |
| op_i | input | 2 | 00 write-enable, 01 write, 10 read, 11 ignored |
| addr_i | input | 6 | Word address |
| wdata_i | input | 16 | Word to write |
| busy_o | output | 1 | Access in progress |
| done_o | output | 1 | One-cycle end-of-access pulse |
| rdata_o | output | 16 | Last word read |
| timeout_o | output | 1 | Last write never saw ready |
| cs_o | output | 1 | EEPROM chip select |
| sk_o | output | 1 | EEPROM shift clock |
| di_o | output | 1 | Serial data to the EEPROM |
| do_i | input | 1 | Serial data from the EEPROM |

## Verification
The hardest case to reach from the ports is the poll timeout, because a working device always becomes ready. The behavioural EEPROM in the bench has a mode in which it stays busy forever once it commits a write. A write-enable followed by a write in that mode drives the FSM through every POLL phase to the limit. A normal read afterwards shows that the error flag is cleared. The bench covers the other end of the poll loop too: it runs a write against a device that is ready on the first poll, and checks the exact phase count that results.

// File: rtl/uw_eeprom_pkg.sv
package uw_eeprom_pkg;

    typedef enum logic [1:0] {
        OP_WREN  = 2'b00,
        OP_WRITE = 2'b01,
        OP_READ  = 2'b10,
        OP_RSVD  = 2'b11
    } uw_op_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_LEAD,
        ST_CMD_LO,
        ST_CMD_HI,
        ST_GAP,
        ST_RD_HI,
        ST_RD_LO,
        ST_WR_LO,
        ST_WR_HI,
        ST_DROP_LO,
        ST_DROP_HI,
        ST_POLL,
        ST_FIN_CS,
        ST_FIN_OFF
    } uw_state_e;

endpackage

// File: rtl/uw_phase_pacer.sv
module uw_phase_pacer #(
    parameter int HALF_CYCLES = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = (HALF_CYCLES > 1) ? $clog2(HALF_CYCLES) : 1;

    logic [CW-1:0] cnt_q;

    assign tick = run && (cnt_q == CW'(HALF_CYCLES - 1));

    always_ff @(posedge clk) begin
        if (!rst_n || !run || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    AST_PACER_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        32'(cnt_q) < HALF_CYCLES); // R3

endmodule

// File: rtl/uw_poll_timer.sv
module uw_poll_timer #(
    parameter int POLL_LIMIT = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic step,
    output logic last
);
    localparam int CW = $clog2(POLL_LIMIT + 1);

    logic [CW-1:0] cnt_q;

    assign last = (cnt_q == CW'(POLL_LIMIT - 1));

    always_ff @(posedge clk) begin
        if (!rst_n || !active) begin
            cnt_q <= '0;
        end else if (step) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    AST_POLL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        32'(cnt_q) < POLL_LIMIT); // R9

endmodule

// File: rtl/uw_eeprom_master.sv
module uw_eeprom_master
    import uw_eeprom_pkg::*;
#(
    parameter int HALF_CYCLES = 3,
    parameter int POLL_LIMIT  = 64,
    parameter int ADDR_W      = 6,
    parameter int DATA_W      = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic [1:0]        op_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [DATA_W-1:0] rdata_o,
    output logic              timeout_o,
    output logic              cs_o,
    output logic              sk_o,
    output logic              di_o,
    input  logic              do_i
);
    localparam int CMD_W = ADDR_W + 5;
    localparam int MAXB  = (CMD_W > DATA_W) ? CMD_W : DATA_W;
    localparam int BC_W  = $clog2(MAXB + 1);

    uw_state_e         state_q, state_d;
    uw_op_e            op_q;
    logic [CMD_W-1:0]  cmd_q;
    logic [DATA_W-1:0] wsr_q, rdata_q;
    logic [BC_W-1:0]   bcnt_q;
    logic              err_q, done_q;
    logic              phase_tick, poll_last, run, accept, last_bit;

    assign run      = (state_q != ST_IDLE);
    assign accept   = (state_q == ST_IDLE) && req_i && (uw_op_e'(op_i) != OP_RSVD);
    assign last_bit = (bcnt_q == BC_W'(1));

    uw_phase_pacer #(.HALF_CYCLES(HALF_CYCLES)) u_pacer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .tick  (phase_tick)
    );

    uw_poll_timer #(.POLL_LIMIT(POLL_LIMIT)) u_poll (
        .clk    (clk),
        .rst_n  (rst_n),
        .active (state_q == ST_POLL),
        .step   ((state_q == ST_POLL) && phase_tick && !do_i && !poll_last),
        .last   (poll_last)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (accept) state_d = (uw_op_e'(op_i) == OP_READ) ? ST_LEAD : ST_CMD_LO;
            ST_LEAD:    if (phase_tick) state_d = ST_CMD_LO;
            ST_CMD_LO:  if (phase_tick) state_d = ST_CMD_HI;
            ST_CMD_HI:  if (phase_tick) begin
                            if (!last_bit)               state_d = ST_CMD_LO;
                            else if (op_q == OP_READ)    state_d = ST_GAP;
                            else if (op_q == OP_WRITE)   state_d = ST_WR_LO;
                            else                         state_d = ST_DROP_LO;
                        end
            ST_GAP:     if (phase_tick) state_d = ST_RD_HI;
            ST_RD_HI:   if (phase_tick) state_d = ST_RD_LO;
            ST_RD_LO:   if (phase_tick) state_d = last_bit ? ST_FIN_CS : ST_RD_HI;
            ST_WR_LO:   if (phase_tick) state_d = ST_WR_HI;
            ST_WR_HI:   if (phase_tick) state_d = last_bit ? ST_DROP_LO : ST_WR_LO;
            ST_DROP_LO: if (phase_tick) state_d = ST_DROP_HI;
            ST_DROP_HI: if (phase_tick) state_d = (op_q == OP_WRITE) ? ST_POLL : ST_FIN_CS;
            ST_POLL:    if (phase_tick && (do_i || poll_last)) state_d = ST_FIN_CS;
            ST_FIN_CS:  if (phase_tick) state_d = ST_FIN_OFF;
            ST_FIN_OFF: if (phase_tick) state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // State register and datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            op_q    <= OP_WREN;
            cmd_q   <= '0;
            wsr_q   <= '0;
            rdata_q <= '0;
            bcnt_q  <= '0;
            err_q   <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            done_q  <= (state_q == ST_FIN_OFF) && phase_tick;
            if (accept) begin
                op_q  <= uw_op_e'(op_i);
                wsr_q <= wdata_i;
                err_q <= 1'b0;
                unique case (uw_op_e'(op_i))
                    OP_READ: begin
                        cmd_q  <= {2'b00, 1'b1, 2'b10, addr_i};
                        bcnt_q <= BC_W'(CMD_W);
                    end
                    OP_WRITE: begin
                        cmd_q  <= {1'b0, 1'b1, 2'b01, addr_i, 1'b0};
                        bcnt_q <= BC_W'(CMD_W - 1);
                    end
                    default: begin
                        cmd_q  <= {1'b0, 1'b1, 2'b00, 2'b11, addr_i[ADDR_W-3:0], 1'b0};
                        bcnt_q <= BC_W'(CMD_W - 1);
                    end
                endcase
            end else if (phase_tick) begin
                unique case (state_q)
                    ST_CMD_HI: begin
                        cmd_q  <= cmd_q << 1;
                        bcnt_q <= last_bit ? BC_W'(DATA_W) : bcnt_q - 1'b1;
                    end
                    ST_RD_HI:  rdata_q <= {do_i, rdata_q[DATA_W-1:1]};
                    ST_RD_LO:  if (!last_bit) bcnt_q <= bcnt_q - 1'b1;
                    ST_WR_HI: begin
                        wsr_q <= wsr_q >> 1;
                        if (!last_bit) bcnt_q <= bcnt_q - 1'b1;
                    end
                    ST_POLL:   if (!do_i && poll_last) err_q <= 1'b1;
                    default:   ;
                endcase
            end
        end
    end

    // Output decode
    always_comb begin
        cs_o = 1'b0;
        sk_o = 1'b0;
        di_o = 1'b0;
        unique case (state_q)
            ST_LEAD, ST_GAP, ST_RD_LO, ST_POLL, ST_FIN_CS: cs_o = 1'b1;
            ST_CMD_LO: begin cs_o = 1'b1; di_o = cmd_q[CMD_W-1]; end
            ST_CMD_HI: begin cs_o = 1'b1; sk_o = 1'b1; di_o = cmd_q[CMD_W-1]; end
            ST_RD_HI:  begin cs_o = 1'b1; sk_o = 1'b1; end
            ST_WR_LO:  begin cs_o = 1'b1; di_o = wsr_q[0]; end
            ST_WR_HI:  begin cs_o = 1'b1; sk_o = 1'b1; di_o = wsr_q[0]; end
            ST_DROP_HI: sk_o = 1'b1;
            default:   ;
        endcase
    end

    assign busy_o    = run;
    assign done_o    = done_q;
    assign rdata_o   = rdata_q;
    assign timeout_o = err_q;

    AST_IDLE_LINES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (!cs_o && !sk_o && !di_o)); // R1
    AST_SK_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o) && !$stable(sk_o)) |-> $past(phase_tick)); // R3
    AST_DI_HOLD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (sk_o && $past(sk_o)) |-> $stable(di_o)); // R4
    AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && $past(busy_o))); // R10
    AST_OP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> $stable(op_q)); // R11
    AST_TIMEOUT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timeout_o) |-> (op_q == OP_WRITE)); // R9

endmodule

// File: tb/uw_eeprom_master_test.sv
module uw_eeprom_master_test;
    localparam int DIV   = 3;
    localparam int PLIM  = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic [1:0]  op = 2'b00;
    logic [5:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic        busy_o, done_o, timeout_o, cs_o, sk_o, di_o, eep_do;
    logic [15:0] rdata_o;

    always #2.5 clk = ~clk;

    uw_eeprom_master #(.HALF_CYCLES(DIV), .POLL_LIMIT(PLIM)) uut (
        .clk(clk), .rst_n(rst_n), .req_i(req), .op_i(op), .addr_i(addr),
        .wdata_i(wdata), .busy_o(busy_o), .done_o(done_o), .rdata_o(rdata_o),
        .timeout_o(timeout_o), .cs_o(cs_o), .sk_o(sk_o), .di_o(di_o), .do_i(eep_do)
    );

    int nchk = 0;
    int nfail = 0;
    int cyc = 0;

    // Behavioural EEPROM responder and line monitor
    logic [15:0] mem [0:63];
    logic        logdi [0:1023];
    logic        logcs [0:1023];
    int          nlog, m_nb, m_mode, m_dc, m_cnt, hw, hw_min, hw_max, di_viol;
    logic [7:0]  m_hdr;
    logic [5:0]  m_addr;
    logic [15:0] m_wbuf;
    logic        m_started, m_wen, m_ready, m_rdbit, cs_p, sk_p, di_p;
    int          m_delay = 0;
    bit          m_stuck = 1'b0;

    function automatic logic [15:0] initval(input int i);
        return 16'(i * 16'h0409) ^ 16'h5A3C;
    endfunction

    assign eep_do = cs_o ? ((m_mode == 1) ? m_rdbit : m_ready) : 1'b0;

    always @(negedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 64; i++) mem[i] = initval(i);
            nlog = 0; m_nb = 0; m_mode = 0; m_dc = 0; m_cnt = 0;
            hw = 0; hw_min = 1000; hw_max = 0; di_viol = 0;
            m_hdr = '0; m_addr = '0; m_wbuf = '0; m_started = 0;
            m_wen = 0; m_ready = 1; m_rdbit = 0; cs_p = 0; sk_p = 0; di_p = 0;
        end else begin
            if (!m_ready && !m_stuck) begin
                if (m_cnt <= 1) m_ready = 1'b1;
                m_cnt--;
            end
            if (cs_p && !cs_o) begin
                if (m_mode == 2 && m_dc == 16 && m_wen) begin
                    mem[m_addr] = m_wbuf;
                    if (m_delay > 0 || m_stuck) begin
                        m_ready = 1'b0;
                        m_cnt = m_delay;
                    end
                end
                m_started = 0; m_nb = 0; m_mode = 0; m_dc = 0;
            end
            if (sk_o && sk_p && di_o != di_p) di_viol++;
            if (sk_o) hw++;
            else if (sk_p) begin
                if (hw < hw_min) hw_min = hw;
                if (hw > hw_max) hw_max = hw;
                hw = 0;
            end
            if (sk_o && !sk_p) begin
                hw = 1;
                if (nlog < 1024) begin
                    logdi[nlog] = di_o;
                    logcs[nlog] = cs_o;
                    nlog++;
                end
                if (cs_o) begin
                    if (!m_started) begin
                        if (di_o) begin m_started = 1; m_nb = 0; end
                    end else if (m_nb < 8) begin
                        m_hdr = {m_hdr[6:0], di_o};
                        m_nb++;
                        if (m_nb == 8) begin
                            m_addr = m_hdr[5:0];
                            m_dc = 0;
                            if (m_hdr[7:6] == 2'b10) begin m_mode = 1; m_rdbit = 0; end
                            else if (m_hdr[7:6] == 2'b01) m_mode = 2;
                            else if (m_hdr[7:4] == 4'b0011) m_wen = 1;
                        end
                    end else if (m_mode == 1 && m_dc < 16) begin
                        m_rdbit = mem[m_addr][m_dc];
                        m_dc++;
                    end else if (m_mode == 2 && m_dc < 16) begin
                        m_wbuf[m_dc] = di_o;
                        m_dc++;
                    end
                end
            end
            cs_p = cs_o; sk_p = sk_o; di_p = di_o;
        end
    end

    task automatic chk(input bit ok, input string req_tag, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req_tag, act, act, exp, exp);
        end
    endtask

    task automatic run_op(input logic [1:0] o, input logic [5:0] a, input logic [15:0] d,
                          output int bcyc, output int s, output bit tmo_acc);
        int n;
        @(negedge clk);
        s = nlog;
        req = 1'b1; op = o; addr = a; wdata = d;
        @(negedge clk);
        req = 1'b0;
        chk(busy_o == 1'b1, "R2 accept", int'(busy_o), 1);
        tmo_acc = timeout_o;
        bcyc = busy_o ? 1 : 0;
        n = 0;
        while (!done_o && n < 5000) begin
            @(negedge clk);
            if (busy_o) bcyc++;
            n++;
        end
    endtask

    task automatic t_reset();
        chk(busy_o == 0 && done_o == 0 && timeout_o == 0, "R1 flags", int'({busy_o, done_o, timeout_o}), 0);
        chk(cs_o == 0 && sk_o == 0 && di_o == 0, "R1 lines", int'({cs_o, sk_o, di_o}), 0);
        chk(rdata_o == 16'h0, "R1 rdata", int'(rdata_o), 0);
    endtask

    task automatic t_wren(input logic [5:0] a);
        int bc, s; bit ta;
        logic [9:0] e;
        run_op(2'b00, a, 16'h0, bc, s, ta);
        e = {1'b0, 1'b1, 2'b00, 2'b11, a[3:0]};
        chk(nlog - s == 11, "R7 wren pulse count", nlog - s, 11);
        for (int i = 0; i < 10; i++)
            chk(logdi[s+i] == e[9-i] && logcs[s+i], "R7 wren bit", int'(logdi[s+i]), int'(e[9-i]));
        chk(logcs[s+10] == 1'b0, "R7 wren cs-low pulse", int'(logcs[s+10]), 0);
        chk(bc == 24 * DIV, "R7 wren length", bc, 24 * DIV);
        chk(m_wen == 1'b1, "R7 wren decoded", int'(m_wen), 1);
    endtask

    task automatic t_write(input logic [5:0] a, input logic [15:0] d, input int exact_len,
                           input bit expect_tmo, output int bc);
        int s; bit ta;
        logic [9:0] e;
        run_op(2'b01, a, d, bc, s, ta);
        e = {1'b0, 1'b1, 2'b01, a};
        chk(nlog - s == 27, "R6 write pulse count", nlog - s, 27);
        for (int i = 0; i < 10; i++)
            chk(logdi[s+i] == e[9-i] && logcs[s+i], "R6 write cmd bit", int'(logdi[s+i]), int'(e[9-i]));
        for (int i = 0; i < 16; i++)
            chk(logdi[s+10+i] == d[i] && logcs[s+10+i], "R6 write data LSB-first", int'(logdi[s+10+i]), int'(d[i]));
        chk(logcs[s+26] == 1'b0, "R7 write cs-low pulse", int'(logcs[s+26]), 0);
        chk(mem[a] == d, "R6 word stored", int'(mem[a]), int'(d));
        chk(timeout_o == expect_tmo, "R9 timeout flag", int'(timeout_o), int'(expect_tmo));
        if (exact_len > 0) chk(bc == exact_len * DIV, "R8 write length", bc, exact_len * DIV);
    endtask

    task automatic t_read(input logic [5:0] a, input logic [15:0] exp, output bit ta);
        int bc, s;
        logic [10:0] e;
        run_op(2'b10, a, 16'h0, bc, s, ta);
        e = {2'b00, 1'b1, 2'b10, a};
        chk(nlog - s == 27, "R5 read pulse count", nlog - s, 27);
        for (int i = 0; i < 11; i++)
            chk(logdi[s+i] == e[10-i] && logcs[s+i], "R5 read cmd bit", int'(logdi[s+i]), int'(e[10-i]));
        chk(rdata_o == exp, "R5 read word", int'(rdata_o), int'(exp));
        chk(bc == 58 * DIV, "R5 read length", bc, 58 * DIV);
        chk(done_o == 1'b1 && busy_o == 1'b0, "R10 done with busy low", int'({done_o, busy_o}), 2);
        @(negedge clk);
        chk(done_o == 1'b0, "R10 done one cycle", int'(done_o), 0);
        chk(rdata_o == exp, "R10 rdata held", int'(rdata_o), int'(exp));
    endtask

    task automatic t_reserved_op();
        int s;
        @(negedge clk);
        s = nlog;
        req = 1'b1; op = 2'b11; addr = 6'd5;
        @(negedge clk);
        req = 1'b0;
        chk(busy_o == 1'b0, "R2 op 11 ignored busy", int'(busy_o), 0);
        repeat (10) @(negedge clk);
        chk(busy_o == 0 && cs_o == 0 && nlog == s, "R2 op 11 ignored lines", nlog - s, 0);
    endtask

    task automatic t_req_while_busy();
        int s, n;
        @(negedge clk);
        s = nlog;
        req = 1'b1; op = 2'b10; addr = 6'd9;
        @(negedge clk);
        req = 1'b0;
        repeat (30) @(negedge clk);
        req = 1'b1; op = 2'b01; addr = 6'd40; wdata = 16'hDEAD;
        @(negedge clk);
        req = 1'b0;
        n = 0;
        while (!done_o && n < 5000) begin @(negedge clk); n++; end
        chk(rdata_o == initval(9), "R11 read undisturbed", int'(rdata_o), int'(initval(9)));
        chk(nlog - s == 27, "R11 pulse count unchanged", nlog - s, 27);
        repeat (4) @(negedge clk);
        chk(busy_o == 1'b0 && mem[40] == initval(40), "R11 late request dropped", int'(mem[40]), int'(initval(40)));
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 150000) begin
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", nchk + 1, nfail + 1);
            $finish;
        end
    end

    initial begin
        int bc;
        bit ta;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_reserved_op();
        t_read(6'd3, initval(3), ta);
        t_read(6'd62, initval(62), ta);
        t_wren(6'd0);
        m_delay = 0;
        t_write(6'd17, 16'hC35A, 57, 1'b0, bc);
        t_read(6'd17, 16'hC35A, ta);
        m_delay = 40;
        t_write(6'd33, 16'h0F81, 0, 1'b0, bc);
        chk(bc > 57 * DIV && bc < (56 + PLIM) * DIV, "R8 poll waits for ready", bc, 60 * DIV);
        t_read(6'd33, 16'h0F81, ta);
        t_req_while_busy();
        m_stuck = 1'b1;
        t_write(6'd50, 16'h8001, 56 + PLIM, 1'b1, bc);
        chk(timeout_o == 1'b1, "R9 timeout held while idle", int'(timeout_o), 1);
        m_stuck = 1'b0;
        m_delay = 0;
        t_read(6'd50, 16'h8001, ta);
        chk(ta == 1'b0, "R9 timeout cleared on accept", int'(ta), 0);
        chk(timeout_o == 1'b0, "R9 timeout stays clear", int'(timeout_o), 0);
        chk(hw_min == DIV && hw_max == DIV, "R3 clock high width", hw_max, DIV);
        chk(di_viol == 0, "R4 data stable while clock high", di_viol, 0);
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule